// File: doc/BRIEF.md
# Scatter-Gather Descriptor Queue

This block holds a short list of DMA segment descriptors that software builds before a multi-segment transfer begins. Software loads one descriptor in two steps. It first writes the segment start address into a holding register. It then writes the command word, which carries the direction bit, the byte-order swap bit, the completion-suppress bit and the segment size. The command write is the commit: it joins the held address and the command fields into a single entry and appends that entry to the queue. A separate configuration write either empties and disables the queue (the clear bit set) or enables it (the clear bit zero). The number of entries still waiting can be read at all times.

A DMA data mover takes entries from the queue over a valid/ready port, in the order they were committed. Only one segment is in flight at a time. Once an entry is popped, the port shows no further entry until the mover acknowledges completion of that segment. If the popped entry had its completion-suppress bit clear, that acknowledgement raises a one-cycle done interrupt. Software normally clears the suppress bit only on the last segment of a list.

Back-pressure rules: `desc_valid` rises only while the queue is enabled, holds at least one entry and has no segment in flight. While `desc_valid` is high and `desc_ready` is low, the payload holds steady. A pop happens on every rising clock edge where both are high.

Top module: `sgq_desc_fifo`

## Requirements
- R1: After reset the queue is disabled and empty: count 0, `desc_valid` low, `done_irq` low, and both sticky flags low.
- R2: A configuration write with bit 16 set empties the queue, disables it, clears both sticky flags and cancels any segment in flight, so a later acknowledgement raises no interrupt. A configuration write with bit 16 clear enables the queue and keeps the entries it holds. A command write in the same cycle as a clearing write is discarded without setting a flag.
- R3: A command write while the queue is enabled and not full, with an aligned held address, appends one entry and raises the count by one on the next cycle. The address used is the value held before that cycle. The held address stays in place for later commits.
- R4: The queue holds at most DEPTH entries (16 by default). A command write while the queue is full or disabled is dropped, leaves the count unchanged and sets the sticky overflow flag. This check takes precedence over R5.
- R5: A command write whose held address has any of bits [2:0] set is dropped, leaves the count unchanged and sets the sticky alignment-error flag.
- R6: Entries leave in first-in first-out order. `desc_valid` is high only while the queue is enabled, not empty and no segment is in flight. The payload is stable while `desc_valid` is high and `desc_ready` is low. Each pop lowers the count by one.
- R7: After a pop, `desc_valid` stays low until `cpl_ack` is seen for that segment. It may rise again on the following cycle.
- R8: `cpl_ack` while a segment is in flight ends that segment. `done_irq` is then high for exactly the next cycle if the popped entry's suppress bit was 0, and stays low if that bit was 1. `cpl_ack` with nothing in flight has no effect.
- R9: A committing command write and a pop in the same cycle both take effect, and the count stays the same.
- R10: The address, the size field (segment bytes / 8 − 1, so 0 means 8 bytes), the direction bit, the swap bit and the suppress bit come out on the consumer port exactly as they were committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_we | input | 1 | Load the segment address holding register |
| addr_wdata | input | ADDR_W | Segment start address |
| cmd_we | input | 1 | Command write; commits one entry |
| cmd_rw | input | 1 | Direction bit of the entry |
| cmd_endian | input | 1 | Byte-order swap bit of the entry |
| cmd_intdis | input | 1 | Completion-suppress bit of the entry |
| cmd_size | input | SIZE_W | Segment size in 8-byte units minus one |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration data; bit 16 is clear/disable |
| cfg_count | output | CNT_W | Entries still waiting |
| cfg_enabled | output | 1 | Queue enabled |
| ovf_flag | output | 1 | Sticky overflow flag (dropped push while full or disabled) |
| align_err | output | 1 | Sticky misaligned-address flag |
| desc_valid | output | 1 | Head entry offered to the consumer |
| desc_ready | input | 1 | Consumer takes the head entry |
| desc_addr | output | ADDR_W | Head entry address |
| desc_size | output | SIZE_W | Head entry size field |
| desc_rw | output | 1 | Head entry direction bit |
| desc_endian | output | 1 | Head entry swap bit |
| desc_intdis | output | 1 | Head entry suppress bit |
| cpl_ack | input | 1 | Consumer acknowledges completion of the in-flight segment |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
Commit and pop can fall in the same rising edge. The bench fills the queue, drains one entry and acknowledges it. It then preloads a new address and, in one cycle, raises `cmd_we` together with `desc_ready` while `desc_valid` is high. It judges the result by the count holding steady, by `desc_valid` dropping for the segment now in flight, and by the head that appears after the acknowledgement being the next older entry rather than the one just committed. Two other pairs are also made to coincide. A clearing configuration write against an in-flight segment must suppress the later interrupt. A full queue against a further commit must set the overflow flag without changing the count.

// File: rtl/sgq_pkg.sv
`timescale 1ns/1ps
package sgq_pkg;

  // Bit of the configuration word that empties and disables the queue.
  localparam int unsigned CFG_CLR_BIT = 16;

  // Outcome of a command write, decided in the cycle of the write.
  typedef enum logic [1:0] {
    PUSH_NONE     = 2'd0,
    PUSH_ACCEPT   = 2'd1,
    PUSH_OVERFLOW = 2'd2,
    PUSH_MISALIGN = 2'd3
  } push_res_e;

  // Address bits that must be zero for an 8-byte aligned segment.
  localparam int unsigned ALIGN_BITS = 3;

endpackage

// File: rtl/sgq_cmd_latch.sv
`timescale 1ns/1ps
module sgq_cmd_latch
  import sgq_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned SIZE_W = 20,
  localparam int unsigned ENT_W = ADDR_W + SIZE_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              cmd_we,
  input  logic              cmd_rw,
  input  logic              cmd_endian,
  input  logic              cmd_intdis,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic              flush,
  input  logic              enabled,
  input  logic              full,
  output push_res_e         push_res,
  output logic [ENT_W-1:0]  push_entry,
  output logic [ALIGN_BITS-1:0] held_low,
  output logic              ovf_flag,
  output logic              align_err
);

  logic [ADDR_W-1:0] addr_hold_q;
  logic              ovf_q;
  logic              err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hold_q <= '0;
    end else if (addr_we) begin
      addr_hold_q <= addr_wdata;
    end
  end

  assign held_low = addr_hold_q[ALIGN_BITS-1:0];

  // Verdict for a command write: clear wins, then capacity/enable, then alignment.
  always_comb begin
    push_res = PUSH_NONE;
    if (cmd_we && !flush) begin
      if (!enabled || full) begin
        push_res = PUSH_OVERFLOW;
      end else if (held_low != '0) begin
        push_res = PUSH_MISALIGN;
      end else begin
        push_res = PUSH_ACCEPT;
      end
    end
  end

  assign push_entry = {addr_hold_q, cmd_size, cmd_rw, cmd_endian, cmd_intdis};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      err_q <= 1'b0;
    end else if (flush) begin
      ovf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (push_res == PUSH_OVERFLOW) ovf_q <= 1'b1;
      if (push_res == PUSH_MISALIGN) err_q <= 1'b1;
    end
  end

  assign ovf_flag  = ovf_q;
  assign align_err = err_q;

endmodule

// File: rtl/sgq_store.sv
`timescale 1ns/1ps
module sgq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned ENT_W = 63,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [ENT_W-1:0] wdata,
  input  logic             pop,
  output logic [ENT_W-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [PTR_W-1:0] wptr_q;
  logic [PTR_W-1:0] rptr_q;
  logic [CNT_W-1:0] count_q;
  logic [ENT_W-1:0] slot_data [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // One register per slot, loaded only when the write pointer selects it.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ENT_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (push && !flush && (wptr_q == PTR_W'(g))) begin
        q <= wdata;
      end
    end
    assign slot_data[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (flush) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) wptr_q <= ptr_next(wptr_q);
      if (pop)  rptr_q <= ptr_next(rptr_q);
      unique case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rdata = slot_data[rptr_q];
  assign count = count_q;
  assign full  = (count_q == CNT_W'(DEPTH));
  assign empty = (count_q == '0);

endmodule

// File: rtl/sgq_track.sv
`timescale 1ns/1ps
module sgq_track (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic pop,
  input  logic pop_intdis,
  input  logic cpl_ack,
  output logic busy,
  output logic done_irq
);

  logic busy_q;
  logic intdis_q;
  logic done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      intdis_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (flush) begin
      busy_q   <= 1'b0;
      intdis_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (pop) begin
        busy_q   <= 1'b1;
        intdis_q <= pop_intdis;
      end else if (busy_q && cpl_ack) begin
        busy_q <= 1'b0;
        done_q <= ~intdis_q;
      end
    end
  end

  assign busy     = busy_q;
  assign done_irq = done_q;

endmodule

// File: rtl/sgq_desc_fifo.sv
`timescale 1ns/1ps
module sgq_desc_fifo
  import sgq_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned SIZE_W = 20,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned ENT_W = ADDR_W + SIZE_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              cmd_we,
  input  logic              cmd_rw,
  input  logic              cmd_endian,
  input  logic              cmd_intdis,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [CNT_W-1:0]  cfg_count,
  output logic              cfg_enabled,
  output logic              ovf_flag,
  output logic              align_err,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [SIZE_W-1:0] desc_size,
  output logic              desc_rw,
  output logic              desc_endian,
  output logic              desc_intdis,
  input  logic              cpl_ack,
  output logic              done_irq
);

  logic              en_q;
  logic              flush;
  logic              full;
  logic              empty;
  logic              busy;
  logic              pop;
  logic              push;
  push_res_e         push_res;
  logic [ENT_W-1:0]  push_entry;
  logic [ENT_W-1:0]  head_entry;
  logic [ALIGN_BITS-1:0] held_low;
  logic              unused_cfg_bits;

  assign flush = cfg_we && cfg_wdata[CFG_CLR_BIT];
  assign unused_cfg_bits = ^{cfg_wdata[31:CFG_CLR_BIT+1], cfg_wdata[CFG_CLR_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (cfg_we) begin
      en_q <= ~cfg_wdata[CFG_CLR_BIT];
    end
  end

  sgq_cmd_latch #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_we    (addr_we),
    .addr_wdata (addr_wdata),
    .cmd_we     (cmd_we),
    .cmd_rw     (cmd_rw),
    .cmd_endian (cmd_endian),
    .cmd_intdis (cmd_intdis),
    .cmd_size   (cmd_size),
    .flush      (flush),
    .enabled    (en_q),
    .full       (full),
    .push_res   (push_res),
    .push_entry (push_entry),
    .held_low   (held_low),
    .ovf_flag   (ovf_flag),
    .align_err  (align_err)
  );

  assign push = (push_res == PUSH_ACCEPT);

  assign desc_valid = en_q && !empty && !busy;
  assign pop        = desc_valid && desc_ready && !flush;

  sgq_store #(
    .DEPTH (DEPTH),
    .ENT_W (ENT_W)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .wdata (push_entry),
    .pop   (pop),
    .rdata (head_entry),
    .count (cfg_count),
    .full  (full),
    .empty (empty)
  );

  assign {desc_addr, desc_size, desc_rw, desc_endian, desc_intdis} = head_entry;

  sgq_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .pop        (pop),
    .pop_intdis (desc_intdis),
    .cpl_ack    (cpl_ack),
    .busy       (busy),
    .done_irq   (done_irq)
  );

  assign cfg_enabled = en_q;

endmodule

// File: rtl/sgq_desc_fifo_chk.sv
`timescale 1ns/1ps
module sgq_desc_fifo_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 40,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_clr,
  input logic              cmd_we,
  input logic [2:0]        held_low,
  input logic [CNT_W-1:0]  cfg_count,
  input logic              cfg_enabled,
  input logic              ovf_flag,
  input logic              align_err,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [ADDR_W-1:0] desc_addr,
  input logic              cpl_ack,
  input logic              done_irq
);

  logic clr_now;
  logic pop_now;
  logic room;
  assign clr_now = cfg_we && cfg_clr;
  assign pop_now = desc_valid && desc_ready;
  assign room    = cfg_enabled && (cfg_count < CNT_W'(DEPTH));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_count <= CNT_W'(DEPTH));

  assert_valid_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (cfg_enabled && cfg_count != '0));

  assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> (cfg_count == '0 && !cfg_enabled && !ovf_flag && !align_err && !desc_valid));

  assert_commit_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !clr_now && room && held_low == 3'd0 && !pop_now)
      |=> cfg_count == $past(cfg_count) + 1'b1);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !clr_now && !room) |=> ovf_flag);

  assert_misalign_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !clr_now && room && held_low != 3'd0 && !pop_now)
      |=> (align_err && $stable(cfg_count)));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready && !clr_now) |=> (desc_valid && $stable(desc_addr)));

  assert_one_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_now |=> !desc_valid);

  assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(cpl_ack));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  assert_push_pop_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !clr_now && room && held_low == 3'd0 && pop_now) |=> $stable(cfg_count));

endmodule

bind sgq_desc_fifo sgq_desc_fifo_chk #(
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_clr     (cfg_wdata[16]),
  .cmd_we      (cmd_we),
  .held_low    (held_low),
  .cfg_count   (cfg_count),
  .cfg_enabled (cfg_enabled),
  .ovf_flag    (ovf_flag),
  .align_err   (align_err),
  .desc_valid  (desc_valid),
  .desc_ready  (desc_ready),
  .desc_addr   (desc_addr),
  .cpl_ack     (cpl_ack),
  .done_irq    (done_irq)
);

// File: tb/sgq_desc_fifo_tb.sv
`timescale 1ns/1ps
module sgq_desc_fifo_tb;

  localparam int unsigned DEPTH  = 16;
  localparam int unsigned ADDR_W = 40;
  localparam int unsigned SIZE_W = 20;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              addr_we = 1'b0;
  logic [ADDR_W-1:0] addr_wdata = '0;
  logic              cmd_we = 1'b0;
  logic              cmd_rw = 1'b0;
  logic              cmd_endian = 1'b0;
  logic              cmd_intdis = 1'b0;
  logic [SIZE_W-1:0] cmd_size = '0;
  logic              cfg_we = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic [CNT_W-1:0]  cfg_count;
  logic              cfg_enabled;
  logic              ovf_flag;
  logic              align_err;
  logic              desc_valid;
  logic              desc_ready = 1'b0;
  logic [ADDR_W-1:0] desc_addr;
  logic [SIZE_W-1:0] desc_size;
  logic              desc_rw;
  logic              desc_endian;
  logic              desc_intdis;
  logic              cpl_ack = 1'b0;
  logic              done_irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sgq_desc_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .cmd_we(cmd_we), .cmd_rw(cmd_rw), .cmd_endian(cmd_endian), .cmd_intdis(cmd_intdis),
    .cmd_size(cmd_size), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_count(cfg_count),
    .cfg_enabled(cfg_enabled), .ovf_flag(ovf_flag), .align_err(align_err),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
    .desc_size(desc_size), .desc_rw(desc_rw), .desc_endian(desc_endian),
    .desc_intdis(desc_intdis), .cpl_ack(cpl_ack), .done_irq(done_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input bit clr);
    cfg_we = 1'b1;
    cfg_wdata = clr ? 32'h0001_0000 : 32'h0;
    step();
    cfg_we = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic addr_write(input logic [ADDR_W-1:0] a);
    addr_we = 1'b1;
    addr_wdata = a;
    step();
    addr_we = 1'b0;
  endtask

  task automatic set_cmd(input bit id, input logic [SIZE_W-1:0] sz, input bit rw, input bit en);
    cmd_intdis = id;
    cmd_size   = sz;
    cmd_rw     = rw;
    cmd_endian = en;
  endtask

  task automatic push(input logic [ADDR_W-1:0] a, input bit id,
                      input logic [SIZE_W-1:0] sz, input bit rw, input bit en);
    addr_write(a);
    set_cmd(id, sz, rw, en);
    cmd_we = 1'b1;
    step();
    cmd_we = 1'b0;
  endtask

  task automatic pop();
    desc_ready = 1'b1;
    step();
    desc_ready = 1'b0;
  endtask

  task automatic ack();
    cpl_ack = 1'b1;
    step();
    cpl_ack = 1'b0;
  endtask

  // Stimulus / expected-result table
  localparam logic [2:0] OP_EN = 3'd0, OP_PUSH = 3'd1, OP_POP = 3'd2, OP_ACK = 3'd3;
  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] addr;
    logic        intdis;
    logic [7:0]  size;
    logic [4:0]  cnt;
    logic        done;
  } vec_t;
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{OP_EN,   16'h0000, 1'b0, 8'h00, 5'd0, 1'b0},
    '{OP_PUSH, 16'h0100, 1'b1, 8'h03, 5'd1, 1'b0},
    '{OP_PUSH, 16'h0208, 1'b1, 8'h00, 5'd2, 1'b0},
    '{OP_PUSH, 16'h0313, 1'b0, 8'h01, 5'd2, 1'b0},
    '{OP_PUSH, 16'h0310, 1'b0, 8'h07, 5'd3, 1'b0},
    '{OP_POP,  16'h0100, 1'b1, 8'h03, 5'd2, 1'b0},
    '{OP_ACK,  16'h0000, 1'b0, 8'h00, 5'd2, 1'b0},
    '{OP_POP,  16'h0208, 1'b1, 8'h00, 5'd1, 1'b0},
    '{OP_ACK,  16'h0000, 1'b0, 8'h00, 5'd1, 1'b0},
    '{OP_POP,  16'h0310, 1'b0, 8'h07, 5'd0, 1'b0},
    '{OP_ACK,  16'h0000, 1'b0, 8'h00, 5'd0, 1'b1}
  };

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "count", 64'(cfg_count), 64'd0);
    chk("R1", "enabled", 64'(cfg_enabled), 64'd0);
    chk("R1", "valid", 64'(desc_valid), 64'd0);
    chk("R1", "done", 64'(done_irq), 64'd0);
    chk("R1", "flags", 64'({ovf_flag, align_err}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string req;
      v = VEC[i];
      req = "R3";
      case (v.op)
        OP_EN: begin
          req = "R2";
          cfg_write(1'b0);
        end
        OP_PUSH: begin
          if (v.addr[2:0] != 3'd0) req = "R5";
          push({24'h0, v.addr}, v.intdis, {12'h0, v.size}, 1'b0, 1'b0);
        end
        OP_POP: begin
          req = "R6";
          chk("R6", "valid before pop", 64'(desc_valid), 64'd1);
          chk("R6", "fifo order addr", 64'(desc_addr), {48'h0, v.addr});
          chk("R10", "size", 64'(desc_size), {56'h0, v.size});
          chk("R10", "intdis", 64'(desc_intdis), 64'(v.intdis));
          pop();
          chk("R7", "valid after pop", 64'(desc_valid), 64'd0);
        end
        default: begin
          req = "R8";
          ack();
        end
      endcase
      chk(req, "count", 64'(cfg_count), 64'(v.cnt));
      chk("R8", "done", 64'(done_irq), 64'(v.done));
    end
    chk("R5", "align flag sticky", 64'(align_err), 64'd1);
    chk("R4", "no overflow yet", 64'(ovf_flag), 64'd0);

    // R2: clear empties, disables and clears flags
    cfg_write(1'b1);
    chk("R2", "count after clear", 64'(cfg_count), 64'd0);
    chk("R2", "disabled", 64'(cfg_enabled), 64'd0);
    chk("R2", "flags cleared", 64'(align_err), 64'd0);

    // R4: push while disabled
    push(40'h40, 1'b0, '0, 1'b0, 1'b0);
    chk("R4", "overflow when disabled", 64'(ovf_flag), 64'd1);
    chk("R4", "count when disabled", 64'(cfg_count), 64'd0);
    cfg_write(1'b1);
    cfg_write(1'b0);
    chk("R2", "enabled", 64'(cfg_enabled), 64'd1);

    // R4: fill to capacity, then one more
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] iv;
      iv = 32'(i);
      push(40'h1000 + 40'(i * 8), iv[0], SIZE_W'(i), iv[1], iv[2]);
    end
    chk("R4", "count full", 64'(cfg_count), 64'(DEPTH));
    chk("R4", "no overflow while filling", 64'(ovf_flag), 64'd0);
    push(40'h9000, 1'b0, '0, 1'b0, 1'b0);
    chk("R4", "overflow when full", 64'(ovf_flag), 64'd1);
    chk("R4", "count held when full", 64'(cfg_count), 64'(DEPTH));

    // R6: stall keeps payload
    step(); step(); step();
    chk("R6", "valid while stalled", 64'(desc_valid), 64'd1);
    chk("R6", "addr while stalled", 64'(desc_addr), 64'h1000);

    pop();
    chk("R6", "count after pop", 64'(cfg_count), 64'(DEPTH - 1));
    chk("R7", "valid low in flight", 64'(desc_valid), 64'd0);
    step();
    chk("R7", "still low without ack", 64'(desc_valid), 64'd0);
    ack();
    chk("R8", "done for intdis=0", 64'(done_irq), 64'd1);
    chk("R7", "valid after ack", 64'(desc_valid), 64'd1);
    step();
    chk("R8", "done one cycle", 64'(done_irq), 64'd0);
    ack();
    chk("R8", "ack idle ignored", 64'(done_irq), 64'd0);

    // R9: commit and pop in the same cycle
    addr_write(40'h2000);
    chk("R9", "head before", 64'(desc_addr), 64'h1008);
    set_cmd(1'b0, '0, 1'b0, 1'b0);
    cmd_we = 1'b1;
    desc_ready = 1'b1;
    step();
    cmd_we = 1'b0;
    desc_ready = 1'b0;
    chk("R9", "count level", 64'(cfg_count), 64'(DEPTH - 1));
    chk("R9", "popped", 64'(desc_valid), 64'd0);
    ack();
    chk("R8", "no done for intdis=1", 64'(done_irq), 64'd0);
    chk("R9", "next older head", 64'(desc_addr), 64'h1010);

    // R2: clear cancels in-flight segment
    pop();
    cfg_write(1'b1);
    ack();
    chk("R2", "no done after clear", 64'(done_irq), 64'd0);
    chk("R2", "count after clear", 64'(cfg_count), 64'd0);

    // R2: enabling write keeps contents
    cfg_write(1'b0);
    push(40'h3000, 1'b1, '0, 1'b0, 1'b0);
    push(40'h3008, 1'b1, '0, 1'b0, 1'b0);
    cfg_write(1'b0);
    chk("R2", "enable keeps entries", 64'(cfg_count), 64'd2);

    // R10: field carriage at extremes
    cfg_write(1'b1);
    cfg_write(1'b0);
    push(40'hF0_0000_0008, 1'b1, {SIZE_W{1'b1}}, 1'b1, 1'b1);
    chk("R10", "addr", 64'(desc_addr), 64'hF0_0000_0008);
    chk("R10", "max size", 64'(desc_size), 64'(20'hFFFFF));
    chk("R10", "rw", 64'(desc_rw), 64'd1);
    chk("R10", "endian", 64'(desc_endian), 64'd1);
    chk("R10", "intdis", 64'(desc_intdis), 64'd1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule